// File: doc/BRIEF.md
# Redundant Channel Output Checker

This block guards a pair of timer channels that are configured to produce identical output waveforms. Each clock it compares the effective outputs of the two channels. If they differ while checking is enabled, it latches a sticky error flag and raises an interrupt request. It also forces both gated outputs to their programmed safe levels. The outputs stay safe until software clears the flag.

For self-test, software can override either channel's raw output with a chosen value through a per-channel force control. A deliberate disagreement between the channels must then trip the checker. When checking is disabled, the block passes the effective outputs straight through and keeps the flag and the interrupt low.

Top module: `redund_out_monitor`

## Requirements
- R1: After reset `err_o` and `irq_o` are 0.
- R2: For channel k (index 0 is channel A, index 1 is channel B), `force_i[k]`=1 makes `force_val_i[k]` replace `raw_i[k]` as the effective value of that channel in the same cycle. Otherwise the effective value is `raw_i[k]`. With no error latched and no live mismatch, `out_o[k]` equals that effective value.
- R3: While `chk_en_i`=1 and the two effective values differ, `out_o` equals `idle_lvl_i` in that same cycle, bit for bit.
- R4: A mismatch seen with `chk_en_i`=1 sets `err_o` and `irq_o` to 1 from the next clock edge.
- R5: While `err_o`=1, `out_o` equals `idle_lvl_i`. Once set, `err_o` stays 1 while `err_clr_i`=0 and `chk_en_i`=1, even if the channels agree again.
- R6: With `err_clr_i`=1, `chk_en_i`=1 and no mismatch, `err_o` and `irq_o` are 0 after the next clock edge, and `out_o` again follows the effective values.
- R7: A mismatch in the same cycle as `err_clr_i`=1 keeps `err_o` set, so a new mismatch takes priority over the clear.
- R8: With `chk_en_i`=0, `err_o` and `irq_o` are 0 after the next clock edge and stay 0. Mismatches are then ignored, and `out_o` follows the effective values.
- R9: Forcing one channel to the opposite of the other channel's value with checking enabled sets the error flag, the same as a real mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chk_en_i | input | 1 | Enable for redundancy checking |
| raw_i | input | 2 | Raw channel outputs, bit 0 = A, bit 1 = B |
| idle_lvl_i | input | 2 | Safe level for each channel |
| force_i | input | 2 | Per-channel force select |
| force_val_i | input | 2 | Per-channel forced value |
| err_clr_i | input | 1 | Clears the error flag |
| out_o | output | 2 | Gated channel outputs |
| err_o | output | 1 | Sticky redundancy error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The model is driven with four input patterns:
- Matching raw waveforms with checking on, which shows that agreement never trips the flag.
- Raw disagreements, which separate the same-cycle safe gating from the flag that appears one edge later.
- Forced overrides on one channel at a time, which tell the force path apart from the raw path and cover the self-test trip.
- Clears issued alone and together with a mismatch, plus enable toggling, which expose the clear priority and the disabled pass-through.

A long random run then mixes all inputs, including the inactive levels.

// File: rtl/redund_pkg.sv
package redund_pkg;
  localparam int unsigned NCH = 2;
  typedef logic [NCH-1:0] ch_vec_t;
endpackage

// File: rtl/redund_force_mux.sv
module redund_force_mux
  import redund_pkg::*;
(
  input  ch_vec_t raw_i,
  input  ch_vec_t force_i,
  input  ch_vec_t force_val_i,
  output ch_vec_t eff_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign eff_o[k] = force_i[k] ? force_val_i[k] : raw_i[k];
  end
endmodule

// File: rtl/redund_err_latch.sv
module redund_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mism_i,
  input  logic clr_i,
  output logic err_o
);
  logic err_q, err_d;

  // a fresh mismatch wins over a clear in the same cycle
  always_comb begin
    err_d = 1'b0;
    if (en_i) err_d = mism_i | (err_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;
endmodule

// File: rtl/redund_out_gate.sv
module redund_out_gate
  import redund_pkg::*;
(
  input  ch_vec_t eff_i,
  input  ch_vec_t idle_i,
  input  logic    safe_i,
  output ch_vec_t out_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign out_o[k] = safe_i ? idle_i[k] : eff_i[k];
  end
endmodule

// File: rtl/redund_out_monitor.sv
module redund_out_monitor
  import redund_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chk_en_i,
  input  logic [1:0] raw_i,
  input  logic [1:0] idle_lvl_i,
  input  logic [1:0] force_i,
  input  logic [1:0] force_val_i,
  input  logic       err_clr_i,
  output logic [1:0] out_o,
  output logic       err_o,
  output logic       irq_o
);
  ch_vec_t eff;
  logic    mism, flag, safe;

  redund_force_mux u_fmux (
    .raw_i      (raw_i),
    .force_i    (force_i),
    .force_val_i(force_val_i),
    .eff_o      (eff)
  );

  assign mism = chk_en_i & (eff[0] ^ eff[1]);

  redund_err_latch u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (chk_en_i),
    .mism_i(mism),
    .clr_i (err_clr_i),
    .err_o (flag)
  );

  // outputs go safe in the mismatch cycle itself, then stay safe via the flag
  assign safe = flag | mism;

  redund_out_gate u_gate (
    .eff_i (eff),
    .idle_i(idle_lvl_i),
    .safe_i(safe),
    .out_o (out_o)
  );

  assign err_o = flag;
  assign irq_o = flag;
endmodule

// File: rtl/redund_out_monitor_chk.sv
module redund_out_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chk_en_i,
  input logic [1:0] raw_i,
  input logic [1:0] idle_lvl_i,
  input logic [1:0] force_i,
  input logic [1:0] force_val_i,
  input logic       err_clr_i,
  input logic [1:0] out_o,
  input logic       err_o,
  input logic       irq_o
);
  logic [1:0] e;
  logic       diff;
  assign e    = (force_i & force_val_i) | (~force_i & raw_i);
  assign diff = e[0] ^ e[1];

  always_comb if (!rst_ni) p_reset_clear_r1: assert (!err_o && !irq_o);

  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && !(chk_en_i && diff)) |-> out_o == e);
  p_live_safe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_en_i && diff) |-> out_o == idle_lvl_i);
  p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_en_i && diff) |=> (err_o && irq_o));
  p_err_safe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> out_o == idle_lvl_i);
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && chk_en_i && !err_clr_i) |=> err_o);
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_en_i && err_clr_i && !diff) |=> !err_o);
  p_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_en_i |=> (!err_o && !irq_o));
endmodule

bind redund_out_monitor redund_out_monitor_chk u_chk (.*);

// File: tb/redund_out_monitor_tb.sv
module redund_out_monitor_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       chk_en_i = 1'b0;
  logic [1:0] raw_i = '0, idle_lvl_i = '0, force_i = '0, force_val_i = '0;
  logic       err_clr_i = 1'b0;
  logic [1:0] out_o;
  logic       err_o, irq_o;

  int total = 0, bad = 0;
  bit done = 0;
  bit m_err = 0;  // reference flag

  always #5 clk_i = ~clk_i;

  redund_out_monitor u_dut (.*);

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // drive after negedge, check comb outputs, advance reference at posedge
  task automatic step(input string req, input logic en, input logic [1:0] raw,
                      input logic [1:0] idle, input logic [1:0] frc,
                      input logic [1:0] fv, input logic clr);
    logic [1:0] eff, exp_out;
    bit mm;
    chk_en_i = en; raw_i = raw; idle_lvl_i = idle; force_i = frc;
    force_val_i = fv; err_clr_i = clr;
    #1;
    for (int k = 0; k < 2; k++) eff[k] = frc[k] ? fv[k] : raw[k];
    mm = en && (eff[0] != eff[1]);
    exp_out = (m_err || mm) ? idle : eff;
    check(req, {out_o, err_o, irq_o}, {exp_out, m_err, m_err});
    @(posedge clk_i);
    if (!en) m_err = 0;
    else if (mm) m_err = 1;
    else if (clr) m_err = 0;
    @(negedge clk_i);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12;
    check("R1", {err_o, irq_o}, 2'b00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: force path with checking off
    step("R2", 0, 2'b00, 2'b11, 2'b01, 2'b01, 0);
    step("R2", 0, 2'b11, 2'b00, 2'b10, 2'b00, 0);
    step("R2", 1, 2'b11, 2'b00, 2'b00, 2'b00, 0);
    step("R2", 1, 2'b00, 2'b11, 2'b00, 2'b00, 0);
    // R3/R4 raw mismatch
    step("R3", 1, 2'b01, 2'b10, 2'b00, 2'b00, 0);
    step("R4", 1, 2'b11, 2'b10, 2'b00, 2'b00, 0);
    // R5 sticky while channels agree
    step("R5", 1, 2'b00, 2'b01, 2'b00, 2'b00, 0);
    step("R5", 1, 2'b11, 2'b01, 2'b00, 2'b00, 0);
    // R7 clear together with mismatch
    step("R7", 1, 2'b10, 2'b00, 2'b00, 2'b00, 1);
    step("R7", 1, 2'b11, 2'b00, 2'b00, 2'b00, 0);
    // R6 clear alone
    step("R6", 1, 2'b11, 2'b00, 2'b00, 2'b00, 1);
    step("R6", 1, 2'b11, 2'b00, 2'b00, 2'b00, 0);
    step("R6", 1, 2'b00, 2'b11, 2'b00, 2'b00, 0);
    // R9 self-test through force
    step("R9", 1, 2'b00, 2'b10, 2'b10, 2'b10, 0);
    step("R9", 1, 2'b00, 2'b10, 2'b00, 2'b00, 0);
    step("R9", 1, 2'b00, 2'b10, 2'b01, 2'b01, 1);
    step("R9", 1, 2'b00, 2'b10, 2'b00, 2'b00, 1);
    step("R9", 1, 2'b00, 2'b10, 2'b00, 2'b00, 0);
    // R8 disable drops flag and ignores mismatch
    step("R8", 1, 2'b01, 2'b00, 2'b00, 2'b00, 0);
    step("R8", 0, 2'b01, 2'b00, 2'b00, 2'b00, 0);
    step("R8", 0, 2'b10, 2'b11, 2'b00, 2'b00, 0);
    step("R8", 0, 2'b01, 2'b11, 2'b00, 2'b00, 0);
    // mixed random run
    for (int i = 0; i < 400; i++)
      step("R2-mix", ($urandom % 8) != 0, 2'($urandom), 2'($urandom),
           2'($urandom % 5 == 0 ? $urandom : 0), 2'($urandom), ($urandom % 6) == 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule